// File: doc/BRIEF.md
# Row-Column 8x8 Two-Dimensional DCT

This block computes an orthonormal Type-II discrete cosine transform of one 8x8 block of signed 16-bit samples per command. A one-cycle `start` pulse while the block is idle makes it fetch the 64 samples from a synchronous source memory, one per cycle, in row-major order. It then runs eight 1D transforms over the rows and eight over the columns. Both passes use a single eight-tap multiply-accumulate core, which produces one coefficient per cycle. Between the passes the results go into a transposing buffer. The 64 rounded and saturated coefficients are then written to a destination memory port, one per cycle, in row-major order.

Row results keep four fraction bits, so the column pass does not stack a second integer rounding error on top of the first. Completion is signalled by a one-cycle `done` and `ready` pulse, and in that cycle `idle` is already high. A new start is accepted in that same cycle, so consecutive blocks can run back to back. Timing is fixed: every block takes 258 cycles from the accepted start to the done pulse.

Top module: `dct2d_top`

## Requirements
- R1: After reset, idle is 1 and done, ready, src_en and dst_en are 0.
- R2: A start seen at a clock edge while idle makes src_en high in the next cycle with src_addr 0. The address then rises by one per cycle through 63, where address = row*8 + column. The source memory returns src_data in the cycle after the one carrying src_en.
- R3: The output at index u*8+v equals round(a(u)·a(v)·Σ x[r][c]·cos((2r+1)uπ/16)·cos((2c+1)vπ/16)) within ±1. Here a(0)=√(1/8) and a(k>0)=1/2, r is the row and c is the column. This holds for samples with magnitude up to 256.
- R4: The results leave on dst_en for 64 consecutive cycles with dst_addr 0..63. Address u*8+v holds vertical frequency u (over rows) and horizontal frequency v (over columns). The first dst_en cycle follows the last src_en cycle after 129 cycles with no memory access.
- R5: Each output is saturated to the range -32768..32767.
- R6: done and ready are high for exactly one cycle: the cycle right after the final dst_en cycle. idle is high from that cycle on.
- R7: A start seen while the block is busy has no effect. It changes neither the address sequence, nor the done cycle, nor the results, and no new fetch follows completion.
- R8: done rises in the 258th cycle after the cycle in which start was accepted. The first src_en is in cycle 1 and the first dst_en is in cycle 194.
- R9: A start in the done cycle is accepted, so the next block's fetch begins in the following cycle.
- R10: src_en and dst_en are never high together, and neither is high while idle or during the two transform passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch a transform; honoured only while idle |
| idle | output | 1 | High when a new command can be taken |
| done | output | 1 | One-cycle completion pulse |
| ready | output | 1 | One-cycle pulse, same cycle as done |
| src_en | output | 1 | Source memory read enable |
| src_addr | output | 6 | Source element address, row*8+column |
| src_data | input | 16 | Signed sample, valid one cycle after src_en |
| dst_en | output | 1 | Destination memory write enable |
| dst_addr | output | 6 | Destination address, vertical*8+horizontal frequency |
| dst_data | output | 16 | Signed coefficient |

## Verification
Two things can land on the same cycle: the done pulse that closes one block and the start that opens the next. The bench provokes this by raising start in the done cycle with a fresh block already loaded. It then judges that the fetch begins in the very next cycle and that both blocks' outputs match the real-valued model. In the second case, start is held high through an entire run, so it is present during the final write cycle. There the bench judges that the done cycle is unchanged and that no fetch follows.

// File: rtl/dct2d_pkg.sv
package dct2d_pkg;

  localparam int LEN    = 8;
  localparam int COEF_W = 16;
  localparam int COEF_Q = 15;

  typedef enum logic [2:0] {PH_IDLE, PH_LOAD, PH_ROW, PH_COL, PH_STORE} phase_t;

  // 0.5*cos(j*pi/16) in Q15, j = 0..8
  function automatic logic signed [COEF_W-1:0] half_cos(input int j);
    case (j)
      0:       return 16'sd16384;
      1:       return 16'sd16069;
      2:       return 16'sd15137;
      3:       return 16'sd13623;
      4:       return 16'sd11585;
      5:       return 16'sd9102;
      6:       return 16'sd6270;
      7:       return 16'sd3196;
      default: return 16'sd0;
    endcase
  endfunction

  // scaled basis a(k)*cos((2n+1)k*pi/16) in Q15, folded onto the first quadrant
  function automatic logic signed [COEF_W-1:0] basis(input logic [2:0] k, input int n);
    int m;
    if (k == 3'd0) return 16'sd11585;
    m = ((2 * n + 1) * int'(k)) % 32;
    if (m > 16) m = 32 - m;
    if (m > 8) return -half_cos(16 - m);
    return half_cos(m);
  endfunction

endpackage

// File: rtl/dct2d_ctrl.sv
module dct2d_ctrl
  import dct2d_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output phase_t            phase,
  output logic [ADDR_W-1:0] idx,
  output logic              idle,
  output logic              done,
  output logic              fetch_en,
  output logic              row_end,
  output logic              col_end
);
  localparam int CNT_W = ADDR_W + 1;
  localparam int ELEMS = 1 << ADDR_W;
  localparam logic [CNT_W-1:0] LAST_E   = CNT_W'(ELEMS - 1);
  localparam logic [CNT_W-1:0] LOAD_END = CNT_W'(ELEMS);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic             done_q;
  logic             pass_last;

  assign pass_last = (cnt == LAST_E);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase)
        PH_IDLE: if (start) begin
          phase <= PH_LOAD;
          cnt   <= '0;
        end
        PH_LOAD: if (cnt == LOAD_END) begin
          phase <= PH_ROW;
          cnt   <= '0;
        end else cnt <= cnt + ONE;
        PH_ROW: if (pass_last) begin
          phase <= PH_COL;
          cnt   <= '0;
        end else cnt <= cnt + ONE;
        PH_COL: if (pass_last) begin
          phase <= PH_STORE;
          cnt   <= '0;
        end else cnt <= cnt + ONE;
        PH_STORE: if (pass_last) begin
          phase  <= PH_IDLE;
          cnt    <= '0;
          done_q <= 1'b1;
        end else cnt <= cnt + ONE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign idle     = (phase == PH_IDLE);
  assign done     = done_q;
  assign fetch_en = (phase == PH_LOAD) && !cnt[ADDR_W];
  assign idx      = cnt[ADDR_W-1:0];
  assign row_end  = (phase == PH_ROW) && pass_last;
  assign col_end  = (phase == PH_COL) && pass_last;

endmodule

// File: rtl/dct2d_mac8.sv
module dct2d_mac8
  import dct2d_pkg::*;
#(
  parameter int IN_W  = 23,
  parameter int ACC_W = 42
) (
  input  logic [LEN-1:0][IN_W-1:0]   vec,
  input  logic [$clog2(LEN)-1:0]     freq,
  output logic signed [ACC_W-1:0]    acc
);
  localparam int PROD_W = IN_W + COEF_W;

  logic signed [PROD_W-1:0] prod [LEN];

  generate
    for (genvar n = 0; n < LEN; n++) begin : g_tap
      assign prod[n] = PROD_W'($signed(vec[n])) * PROD_W'(basis(freq, n));
    end
  endgenerate

  always_comb begin
    acc = '0;
    for (int n = 0; n < LEN; n++) acc = acc + ACC_W'(prod[n]);
  end

endmodule

// File: rtl/dct2d_top.sv
module dct2d_top
  import dct2d_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int FRAC_W = 4,
  localparam int ADDR_W = 2 * $clog2(LEN)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  output logic                     idle,
  output logic                     done,
  output logic                     ready,
  output logic                     src_en,
  output logic [ADDR_W-1:0]        src_addr,
  input  logic signed [DATA_W-1:0] src_data,
  output logic                     dst_en,
  output logic [ADDR_W-1:0]        dst_addr,
  output logic signed [DATA_W-1:0] dst_data
);
  localparam int IDX_W  = $clog2(LEN);
  localparam int ELEMS  = LEN * LEN;
  localparam int IW     = DATA_W + IDX_W + FRAC_W;
  localparam int ACC_W  = IW + COEF_W + IDX_W;
  localparam int SH_ROW = COEF_Q - FRAC_W;
  localparam int SH_COL = COEF_Q + FRAC_W;

  function automatic logic signed [IW-1:0] widen(input logic signed [DATA_W-1:0] s);
    return {{(IW-DATA_W){s[DATA_W-1]}}, s};
  endfunction

  function automatic logic signed [IW-1:0] row_round(input logic signed [ACC_W-1:0] a);
    logic signed [ACC_W-1:0] t;
    t = (a + (ACC_W'(1) <<< (SH_ROW - 1))) >>> SH_ROW;
    return t[IW-1:0];
  endfunction

  function automatic logic signed [DATA_W-1:0] col_round_sat(input logic signed [ACC_W-1:0] a);
    logic signed [ACC_W-1:0] t, hi, lo;
    t  = (a + (ACC_W'(1) <<< (SH_COL - 1))) >>> SH_COL;
    hi = ACC_W'((1 <<< (DATA_W - 1)) - 1);
    lo = -hi - ACC_W'(1);
    if (t > hi) return hi[DATA_W-1:0];
    if (t < lo) return lo[DATA_W-1:0];
    return t[DATA_W-1:0];
  endfunction

  phase_t             phase;
  logic [ADDR_W-1:0]  idx;
  logic               fetch_en;
  logic               row_end;
  logic               col_end;
  logic [IDX_W-1:0]   grp;
  logic [IDX_W-1:0]   freq;
  logic [ADDR_W-1:0]  tr_addr;

  logic signed [DATA_W-1:0] smp_buf [ELEMS];
  logic signed [IW-1:0]     mid_buf [ELEMS];
  logic signed [DATA_W-1:0] res_buf [ELEMS];

  logic                     rd_pend_q;
  logic [ADDR_W-1:0]        rd_addr_q;
  logic [LEN-1:0][IW-1:0]   tap_vec;
  logic signed [ACC_W-1:0]  acc;

  dct2d_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .phase    (phase),
    .idx      (idx),
    .idle     (idle),
    .done     (done),
    .fetch_en (fetch_en),
    .row_end  (row_end),
    .col_end  (col_end)
  );

  assign grp     = idx[ADDR_W-1:IDX_W];
  assign freq    = idx[IDX_W-1:0];
  assign tr_addr = {freq, grp};

  // one vector per group: a sample row in the row pass, a transposed row in the column pass
  always_comb begin
    for (int n = 0; n < LEN; n++) begin
      if (phase == PH_COL) tap_vec[n] = mid_buf[{grp, IDX_W'(n)}];
      else                 tap_vec[n] = widen(smp_buf[{grp, IDX_W'(n)}]);
    end
  end

  dct2d_mac8 #(.IN_W(IW), .ACC_W(ACC_W)) mac_i (
    .vec  (tap_vec),
    .freq (freq),
    .acc  (acc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend_q <= 1'b0;
      rd_addr_q <= '0;
    end else begin
      rd_pend_q <= fetch_en;
      rd_addr_q <= idx;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_pend_q)       smp_buf[rd_addr_q] <= src_data;
    if (phase == PH_ROW) mid_buf[tr_addr]   <= row_round(acc);
    if (phase == PH_COL) res_buf[tr_addr]   <= col_round_sat(acc);
  end

  assign ready    = done;
  assign src_en   = fetch_en;
  assign src_addr = idx;
  assign dst_en   = (phase == PH_STORE);
  assign dst_addr = idx;
  assign dst_data = res_buf[idx];

endmodule

// File: rtl/dct2d_chk.sv
module dct2d_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              idle,
  input logic              done,
  input logic              src_en,
  input logic [ADDR_W-1:0] src_addr,
  input logic              dst_en,
  input logic [ADDR_W-1:0] dst_addr,
  input logic              row_end,
  input logic              col_end
);

  AST_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && start) |=> (src_en && src_addr == '0)) else $error("launch"); // R2
  AST_SRC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (src_en && src_addr != '0) |-> ($past(src_en) && src_addr == $past(src_addr) + 1'b1)) else $error("src step"); // R2
  AST_DST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_en && dst_addr != '0) |-> ($past(dst_en) && dst_addr == $past(dst_addr) + 1'b1)) else $error("dst step"); // R4
  AST_COL_TO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    col_end |=> (dst_en && dst_addr == '0)) else $error("store start"); // R4
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_en && dst_addr == {ADDR_W{1'b1}}) |=> done) else $error("done late"); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done width"); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> idle) else $error("done not idle"); // R6
  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && start) |=> !(src_en && src_addr == '0)) else $error("busy relaunch"); // R7
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(src_en && dst_en)) else $error("overlap"); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (!src_en && !dst_en)) else $error("idle traffic"); // R10
  AST_PASS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    row_end |=> (!src_en && !dst_en)) else $error("pass traffic"); // R10

endmodule

bind dct2d_top dct2d_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/dct2d_top_tb_top.sv
module dct2d_top_tb_top;

  localparam int  CLK_PERIOD = 10;
  localparam int  WD_CYCLES  = 150000;
  localparam real PI         = 3.14159265358979;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic idle, done, ready, src_en, dst_en;
  logic [5:0] src_addr, dst_addr;
  logic signed [15:0] src_data;
  logic signed [15:0] dst_data;

  logic signed [15:0] src_mem [64];
  logic signed [15:0] dst_mem [64];

  int n_chk = 0;
  int n_fail = 0;
  bit all_done = 1'b0;
  int lcg = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  dct2d_top dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .idle(idle), .done(done), .ready(ready),
    .src_en(src_en), .src_addr(src_addr), .src_data(src_data),
    .dst_en(dst_en), .dst_addr(dst_addr), .dst_data(dst_data)
  );

  // synchronous source memory, one cycle read latency
  always @(posedge clk) if (src_en) src_data <= src_mem[src_addr];
  // destination memory capture
  always @(negedge clk) if (dst_en) dst_mem[dst_addr] = dst_data;

  task automatic check(input bit ok, input string req, input string what, input int got, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic int next_rand();
    lcg = lcg * 1103515245 + 12345;
    return ((lcg >>> 16) & 511) - 256;
  endfunction

  // kinds: 0 impulse, 1 flat, 2 horizontal ramp, 3 random, 4 max, 5 min, 6 vertical ramp
  task automatic load_block(input int kind);
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++) begin
        int v;
        case (kind)
          0: v = (r == 0 && c == 0) ? 512 : 0;
          1: v = 100;
          2: v = c * 40 - 140;
          3: v = next_rand();
          4: v = 32767;
          5: v = -32768;
          default: v = r * 30 - 100;
        endcase
        src_mem[r*8+c] = 16'(v);
      end
  endtask

  task automatic compare_block(input string req, input string tag);
    for (int u = 0; u < 8; u++)
      for (int v = 0; v < 8; v++) begin
        real s, d;
        int got;
        s = 0.0;
        for (int r = 0; r < 8; r++)
          for (int c = 0; c < 8; c++)
            s = s + real'(src_mem[r*8+c]) * $cos((2*r+1)*u*PI/16.0) * $cos((2*c+1)*v*PI/16.0);
        s = s * ((u == 0) ? $sqrt(0.125) : 0.5) * ((v == 0) ? $sqrt(0.125) : 0.5);
        if (s > 32767.0) s = 32767.0;
        if (s < -32768.0) s = -32768.0;
        got = int'(dst_mem[u*8+v]);
        d = real'(got) - s;
        n_chk++;
        if (d > 1.0 || d < -1.0) begin
          n_fail++;
          $display("FAIL %s %s coef u=%0d v=%0d: got %0d expected %0.3f", req, tag, u, v, got, s);
        end
      end
  endtask

  // start is raised at the current negedge (cycle 0); returns at the negedge of the done cycle
  task automatic launch_and_watch(input string tag, input int poke_lo, input int poke_hi);
    int first_src = -1, first_dst = -1, n_src = 0, n_dst = 0, done_cyc = -1;
    bit ready_ok = 1'b0;
    start = 1'b1;
    for (int j = 1; j <= 300 && done_cyc < 0; j++) begin
      @(negedge clk);
      start = (j >= poke_lo && j <= poke_hi);
      if (src_en) begin
        if (first_src < 0) first_src = j;
        n_src++;
      end
      if (dst_en) begin
        if (first_dst < 0) first_dst = j;
        n_dst++;
      end
      if (done) begin
        done_cyc = j;
        ready_ok = ready && idle;
      end
    end
    check(first_src == 1, "R2", {tag, " first fetch cycle"}, first_src, 1);
    check(n_src == 64, "R2", {tag, " fetch count"}, n_src, 64);
    check(first_dst == 194, "R8", {tag, " first write cycle"}, first_dst, 194);
    check(n_dst == 64, "R4", {tag, " write count"}, n_dst, 64);
    check(done_cyc == 258, "R8", {tag, " done cycle"}, done_cyc, 258);
    check(ready_ok, "R6", {tag, " ready and idle with done"}, int'(ready_ok), 1);
  endtask

  task automatic after_done(input string tag);
    @(negedge clk);
    check(!done && !ready, "R6", {tag, " pulse width"}, int'(done) + int'(ready), 0);
    check(idle && !src_en, "R6", {tag, " idle after done"}, int'(idle), 1);
  endtask

  task automatic test_reset();
    check(idle == 1'b1, "R1", "reset idle", int'(idle), 1);
    check(done == 1'b0, "R1", "reset done", int'(done), 0);
    check(ready == 1'b0, "R1", "reset ready", int'(ready), 0);
    check(!src_en && !dst_en, "R1", "reset enables", int'(src_en) + int'(dst_en), 0);
  endtask

  task automatic test_single(input int kind, input string req, input string tag);
    load_block(kind);
    launch_and_watch(tag, -1, -1);
    compare_block(req, tag);
    after_done(tag);
  endtask

  task automatic test_busy_start();
    load_block(3);
    launch_and_watch("R7 busy", 1, 257);
    compare_block("R7", "busy");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(idle && !src_en, "R7", "no relaunch after busy start", int'(src_en), 0);
    end
  endtask

  task automatic test_back_to_back();
    load_block(6);
    launch_and_watch("R9 first", -1, -1);
    compare_block("R9", "first block");
    load_block(3);
    launch_and_watch("R9 second", -1, -1);
    compare_block("R9", "second block");
    after_done("R9");
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_single(0, "R3", "impulse");
    test_single(1, "R3", "flat");
    test_single(2, "R4", "horizontal ramp");
    test_single(6, "R4", "vertical ramp");
    test_single(3, "R3", "random a");
    test_single(3, "R3", "random b");
    test_single(4, "R5", "positive full scale");
    test_single(5, "R5", "negative full scale");
    test_busy_start();
    test_back_to_back();
    all_done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!all_done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got %0d cycles without completion expected fewer", WD_CYCLES);
      summary();
      $finish;
    end
  end

endmodule